// File: doc/BRIEF.md
# MDIO Management Command Interface

This block lets a processor run PHY management transactions over a two-wire MDIO bus through two 32-bit registers on a simple register bus. Software puts a packed command word into the command register. The word holds the PHY address, the register number, the write data and the start bits. Software then polls the status register. Each transaction type has a sticky completion flag. The status register also shows a busy bit and the last 16-bit value read from a PHY.

Inside the block, a clock divider produces MDC from the system clock. A frame engine shifts out one Clause 22 frame per command and drives MDIO through an output-enable pin. On reads it releases the line at the turnaround and samples the returned bits. A command is accepted only while the bus is idle. The flag that matches the command type clears when the command is accepted and sets again when the frame completes. This gives software a simple "wait for clear, issue, wait for set" sequence.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: The command register is register index 0. Its fields are: PHY address in bits 4:0, PHY register number in bits 12:8, write value in bits 31:16, write start in bit 13 and read start in bit 14. When both start bits are set, a read is performed.
- R2: The status register is register index 1. Its fields are: write-done flag in bit 0, read-ready flag in bit 1, busy in bit 2, and the last read value in bits 31:16. Every field is zero after reset.
- R3: Accepting a command clears the flag for its type and raises busy on the next clock edge. When the frame ends, busy drops and that flag is set on the same edge.
- R4: A command word written while busy is ignored. No frame is started, no flag changes, and the stored command word is not overwritten.
- R5: Each frame is 64 MDC cycles long, sent MSB first. The order is: 32 ones, start bits 0 then 1, opcode (0,1 for write; 1,0 for read), 5 PHY address bits, 5 register bits, turnaround, then 16 data bits. A write drives turnaround 1 then 0 and keeps MDIO enabled for the whole frame.
- R6: In a read, the output enable is low from the first turnaround bit to the end of the frame. The 16 data bits are sampled from MDIO on the rising edge of MDC and appear in status bits 31:16.
- R7: MDC stays low whenever the block is idle. During a frame its period is 2*DIV_HALF system clocks. The MDIO output changes only when MDC falls, or when a frame starts.
- R8: A command word with neither start bit set is stored but starts no frame, and the status is unchanged.
- R9: Register reads return data on the clock edge that samples reg_rd. Index 0 returns the stored command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register index (0 command, 1 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high = drive) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions check on every cycle that MDC is low and the output enable is off while the block is idle. They also check that the MDIO output holds steady except on falling MDC edges, and that no command is accepted while busy. They further check that accepting a command clears its flag and raises busy, that finishing a frame sets a flag, and that a read keeps the line released from the turnaround onward. Only the bench scenarios can show the things a cycle-local property cannot see. These are the exact bit order of a whole frame, the MDC period, the read value a modelled PHY returns, read priority when both start bits are set, and that an ignored or empty command leaves no trace at the ports.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int REG_W      = 32;
  localparam int FRAME_BITS = 64;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  // command word layout
  localparam int CMD_PHY_LSB  = 0;
  localparam int CMD_REG_LSB  = 8;
  localparam int CMD_WR_BIT   = 13;
  localparam int CMD_RD_BIT   = 14;
  localparam int CMD_DATA_LSB = 16;

  // status word layout
  localparam int ST_WDONE    = 0;
  localparam int ST_RRDY     = 1;
  localparam int ST_BUSY     = 2;
  localparam int ST_DATA_LSB = 16;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] data;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic tick_rise,
  output logic tick_fall
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  always_comb begin
    wrap      = run && (cnt == LAST);
    tick_rise = wrap && !mdc;
    tick_fall = wrap && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  mdio_req_t        req,
  input  logic             tick_rise,
  input  logic             tick_fall,
  input  logic             mdio_i,
  output logic             busy,
  output logic             rd_op,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             fin,
  output logic [15:0]      rx_word
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(TA_FIRST);
  localparam logic [CNT_W-1:0] DAT_IDX  = CNT_W'(DATA_FIRST);

  logic [FRAME_BITS-1:0] sh;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      nxt_cnt;

  always_comb begin
    frame = {{32{1'b1}}, 2'b01, (req.rd ? OP_RD : OP_WR), req.phy, req.regn,
             (req.rd ? 2'b11 : 2'b10), req.data};
    fin     = busy && tick_fall && (bit_cnt == LAST_BIT);
    nxt_cnt = bit_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      rd_op   <= 1'b0;
      bit_cnt <= '0;
      sh      <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rx_word <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        rd_op   <= req.rd;
        bit_cnt <= '0;
        sh      <= frame;
        mdio_o  <= frame[FRAME_BITS-1];
        mdio_oe <= 1'b1;
      end
    end else begin
      if (tick_rise && rd_op && (bit_cnt >= DAT_IDX))
        rx_word <= {rx_word[14:0], mdio_i};
      if (fin) begin
        busy    <= 1'b0;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b0;
      end else if (tick_fall) begin
        bit_cnt <= nxt_cnt;
        sh      <= {sh[FRAME_BITS-2:0], 1'b0};
        mdio_o  <= sh[FRAME_BITS-2];
        mdio_oe <= !(rd_op && (nxt_cnt >= TA_IDX));
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_regs.sv
module mdio_cmd_regs
  import mdio_cmd_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              rd_op,
  input  logic              fin,
  input  logic [15:0]       rx_word,
  output logic              acc_wr,
  output logic              acc_rd,
  output mdio_req_t         req,
  output logic              flag_wr,
  output logic              flag_rd
);
  localparam logic [ADDR_W-1:0] IDX_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IDX_STAT = ADDR_W'(1);

  logic [REG_W-1:0] cmd_q;
  logic [15:0]      rd_data_q;
  logic             cmd_wr_idle;
  logic [REG_W-1:0] status;

  always_comb begin
    cmd_wr_idle = reg_wr && (reg_addr == IDX_CMD) && !busy;
    acc_rd      = cmd_wr_idle && reg_wdata[CMD_RD_BIT];
    acc_wr      = cmd_wr_idle && reg_wdata[CMD_WR_BIT] && !reg_wdata[CMD_RD_BIT];
    req.rd      = reg_wdata[CMD_RD_BIT];
    req.phy     = reg_wdata[CMD_PHY_LSB +: 5];
    req.regn    = reg_wdata[CMD_REG_LSB +: 5];
    req.data    = reg_wdata[CMD_DATA_LSB +: 16];
    status                   = '0;
    status[ST_WDONE]         = flag_wr;
    status[ST_RRDY]          = flag_rd;
    status[ST_BUSY]          = busy;
    status[ST_DATA_LSB +: 16] = rd_data_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      rd_data_q <= '0;
      flag_wr   <= 1'b0;
      flag_rd   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (cmd_wr_idle) cmd_q <= reg_wdata;
      if (acc_wr) flag_wr <= 1'b0;
      else if (fin && !rd_op) flag_wr <= 1'b1;
      if (acc_rd) flag_rd <= 1'b0;
      else if (fin && rd_op) flag_rd <= 1'b1;
      if (fin && rd_op) rd_data_q <= rx_word;
      if (reg_rd) begin
        if (reg_addr == IDX_CMD)       reg_rdata <= cmd_q;
        else if (reg_addr == IDX_STAT) reg_rdata <= status;
        else                           reg_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int ADDR_W   = 1,
  parameter int DIV_HALF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic             eng_busy, eng_rd_op, eng_fin;
  logic [CNT_W-1:0] eng_bit_cnt;
  logic [15:0]      eng_rx;
  logic             tick_rise, tick_fall;
  logic             acc_wr, acc_rd, flag_wr, flag_rd;
  mdio_req_t        req;

  mdio_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(eng_busy), .rd_op(eng_rd_op), .fin(eng_fin), .rx_word(eng_rx),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .req(req),
    .flag_wr(flag_wr), .flag_rd(flag_rd)
  );

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst(rst), .run(eng_busy), .mdc(mdc),
    .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst(rst), .start(acc_wr || acc_rd), .req(req),
    .tick_rise(tick_rise), .tick_fall(tick_fall), .mdio_i(mdio_i),
    .busy(eng_busy), .rd_op(eng_rd_op), .bit_cnt(eng_bit_cnt),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .fin(eng_fin), .rx_word(eng_rx)
  );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk
  import mdio_cmd_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             rd_op,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             acc_wr,
  input logic             acc_rd,
  input logic             flag_wr,
  input logic             flag_rd
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc); // R7
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe); // R6
  AST_MDIO_CHANGES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o)); // R7
  AST_NO_ACCEPT_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(acc_wr || acc_rd)); // R4
  AST_WR_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    acc_wr |=> (busy && !flag_wr)); // R3
  AST_RD_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> (busy && !flag_rd)); // R3
  AST_END_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (flag_wr || flag_rd)); // R3
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_op && (bit_cnt >= CNT_W'(TA_FIRST))) |-> !mdio_oe); // R6
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_op) |-> mdio_oe); // R5
  AST_SINGLE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !(acc_wr && acc_rd)); // R1
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(eng_busy), .rd_op(eng_rd_op), .bit_cnt(eng_bit_cnt),
  .acc_wr(acc_wr), .acc_rd(acc_rd), .flag_wr(flag_wr), .flag_rd(flag_rd)
);

// File: tb/mdio_cmd_ctrl_test.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_test;
  localparam int HALF = 4;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [0:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  always #2.5 clk = ~clk;

  mdio_cmd_ctrl #(.ADDR_W(1), .DIV_HALF(HALF)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0, fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  // PHY model
  logic [63:0] cap = '0, oe_bits = '0;
  logic [15:0] phy_val = '0;
  logic        phy_drv = 1'b1;
  int          pcnt = 0;
  longint      rise_t [2];
  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  always @(posedge mdc) begin
    if (pcnt < 64) begin
      cap = {cap[62:0], mdio_o};
      oe_bits[63-pcnt] = mdio_oe;
      if (pcnt < 2) rise_t[pcnt] = cyc;
    end
    pcnt++;
  end
  always @(negedge mdc) begin
    if (pcnt == 47) phy_drv = 1'b0;
    else if (pcnt >= 48 && pcnt <= 63) phy_drv = phy_val[63-pcnt];
    else phy_drv = 1'b1;
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 1'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(int a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 1'(a);
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(1, s);
      if (!s[2]) break;
    end
  endtask

  function automatic logic [31:0] cmd_word(bit w, bit r, logic [4:0] p,
                                           logic [4:0] g, logic [15:0] d);
    return {d, 1'b0, r, w, g, 3'b000, p};
  endfunction

  function automatic logic [63:0] exp_frame(bit r, logic [4:0] p,
                                            logic [4:0] g, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), p, g,
            (r ? 2'b11 : 2'b10), d};
  endfunction

  task automatic txn(bit r, bit both, logic [4:0] p, logic [4:0] g,
                     logic [15:0] d, logic [15:0] pv);
    logic [31:0] s;
    logic [63:0] ef;
    pcnt = 0; phy_val = pv;
    wr_reg(0, cmd_word(both | !r, r, p, g, d));
    rd_reg(1, s);
    chk(s[2] == 1'b1, "R3 busy after accept", 64'(s[2]), 64'd1);
    chk(s[r ? 1 : 0] == 1'b0, "R3 flag cleared on accept", 64'(s), 64'd0);
    wait_idle();
    rd_reg(1, s);
    chk(s[r ? 1 : 0] == 1'b1 && !s[2], "R3 flag set at end", 64'(s[2:0]),
        r ? 64'd2 : 64'd1);
    ef = exp_frame(r, p, g, d);
    if (r) begin
      chk(cap[63:18] == ef[63:18], "R5 read frame header", cap, ef);
      chk(s[31:16] == pv, "R6 read value in status", 64'(s[31:16]), 64'(pv));
      chk(oe_bits[18] == 1'b1 && oe_bits[17] == 1'b0 && oe_bits[0] == 1'b0,
          "R6 release at turnaround", oe_bits, 64'hFFFF_FFFF_FFFC_0000);
      if (both) chk(cap[29:28] == 2'b10, "R1 read priority", 64'(cap[29:28]), 64'd2);
    end else begin
      chk(cap == ef, "R5 write frame", cap, ef);
      chk(oe_bits == '1, "R5 write driven", oe_bits, '1);
    end
    chk(pcnt == 64, "R5 frame length", 64'(pcnt), 64'd64);
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] s, c;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    rd_reg(1, s);
    chk(s == 32'd0, "R2 reset status", 64'(s), 64'd0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R7 idle lines", 64'({mdc, mdio_oe}), 64'd0);

    txn(1'b0, 1'b0, 5'd5, 5'd17, 16'hA5C3, 16'h0);
    chk(rise_t[1] - rise_t[0] == 2 * HALF, "R7 mdc period",
        64'(rise_t[1] - rise_t[0]), 64'(2 * HALF));
    txn(1'b1, 1'b0, 5'd31, 5'd0, 16'h0, 16'h8001);
    txn(1'b1, 1'b1, 5'd2, 5'd9, 16'h1234, 16'h7E5A);
    rd_reg(1, s);
    chk(s[0] == 1'b1 && s[1] == 1'b1, "R2 both flags sticky", 64'(s[1:0]), 64'd3);

    // R4: second command while busy
    pcnt = 0;
    wr_reg(0, cmd_word(1'b1, 1'b0, 5'd1, 5'd3, 16'hBEEF));
    repeat (40) @(negedge clk);
    wr_reg(0, cmd_word(1'b0, 1'b1, 5'd7, 5'd7, 16'h0));
    wait_idle();
    repeat (300) @(negedge clk);
    chk(pcnt == 64, "R4 no second frame", 64'(pcnt), 64'd64);
    chk(cap == exp_frame(1'b0, 5'd1, 5'd3, 16'hBEEF), "R4 first frame kept", cap,
        exp_frame(1'b0, 5'd1, 5'd3, 16'hBEEF));
    rd_reg(1, s);
    chk(s[1:0] == 2'b11, "R4 read flag untouched", 64'(s[1:0]), 64'd3);
    rd_reg(0, c);
    chk(c == cmd_word(1'b1, 1'b0, 5'd1, 5'd3, 16'hBEEF), "R4 R9 cmd not overwritten",
        64'(c), 64'(cmd_word(1'b1, 1'b0, 5'd1, 5'd3, 16'hBEEF)));

    // R8: no start bits
    pcnt = 0;
    wr_reg(0, cmd_word(1'b0, 1'b0, 5'd9, 5'd4, 16'h5555));
    repeat (100) @(negedge clk);
    chk(pcnt == 0 && mdc == 1'b0, "R8 no frame", 64'(pcnt), 64'd0);
    rd_reg(1, c);
    chk(c == s, "R8 status unchanged", 64'(c), 64'(s));
    rd_reg(0, c);
    chk(c == cmd_word(1'b0, 1'b0, 5'd9, 5'd4, 16'h5555), "R9 cmd readback",
        64'(c), 64'(cmd_word(1'b0, 1'b0, 5'd9, 5'd4, 16'h5555)));

    for (int i = 0; i < 8; i++) begin
      txn(1'($urandom), 1'($urandom), 5'($urandom), 5'($urandom),
          16'($urandom), 16'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule